// File: doc/BRIEF.md
# Time-of-Day Aligned Pulse Generator

This block keeps a free-running time-of-day clock, split into a seconds count and a nanoseconds count, and drives one output pin with a single pulse per second that is locked to that clock. Each time the nanoseconds count wraps and the seconds count steps, the pin stays at its inactive level for a programmed delay, then goes to its active level for a programmed width. The delay and the width are both given in nanoseconds. Edge placement resolves to the clock tick on which the nanoseconds count first reaches the programmed value.

Software programs three registers through a simple write port and reads them back through a combinational read port. The configuration word carries an action field, a synchronize enable, an output polarity bit and a domain bit. Values written are held in the register file at once, but the pulse logic only picks them up at the next seconds rollover, so a running second is never disturbed. A pulse whose delay plus width would cross the next second boundary is cut off at that boundary.

The pulse sequencer is a four-state machine. ST_IDLE holds the inactive level for a second in which the pin is not enabled. ST_DELAY waits for the delay to elapse. ST_HIGH drives the active level. ST_DONE holds the inactive level after the pulse until the second ends. The transitions are named as follows. T_ROLL happens at every rollover and reloads the state from the new settings; it goes to ST_IDLE, ST_DELAY, ST_HIGH or ST_DONE depending on where the first tick of the new second falls. T_START goes from ST_DELAY to ST_HIGH when the delay is reached. T_SKIP goes from ST_DELAY to ST_DONE when one coarse tick steps past the whole window. T_END goes from ST_HIGH to ST_DONE when the width has elapsed.

Top module: `tod_pulse_gen`

## Requirements
- R1: At each clock the nanoseconds count advances by NS_INC. It stays below NS_PER_SEC, and when it would reach NS_PER_SEC it wraps by subtracting NS_PER_SEC.
- R2: The seconds count rises by exactly one on every nanoseconds wrap and holds at all other clocks.
- R3: When the configuration word has action field bits [5:3] = 1 (clock action) and synchronize bit 2 = 1, the pin is at its active level exactly on the ticks whose nanoseconds value t satisfies low <= t < low + high. Here high is the register at byte offset 0x14 and low is the register at offset 0x18.
- R4: Within an enabled second, the pin stays at its inactive level on every tick with t below the low (delay) register.
- R5: A window that would extend past the second boundary is truncated: the pin returns to its inactive level at the first tick of the next second unless the new second's settings start a pulse there. Ticks with t >= low + high are inactive.
- R6: Polarity bit 1 of the configuration word selects the level. With 0 the active level is 1 and the inactive level is 0; with 1 both are inverted.
- R7: If the action field is not 1 or the synchronize bit is 0, the pin holds its inactive level (given by bit 1) for the whole second. Domain bit 0 is stored and read back but does not change the waveform.
- R8: A high register of 0 gives no pulse in that second.
- R9: A register write changes the waveform only from the next seconds rollover on; the second in which the write happens follows the previous settings.
- R10: Reads return the written values: configuration bits [5:0] at offset 0x00 (upper bits read 0), high at 0x14 and low at 0x18. Any other offset reads 0, and writes to it change nothing.
- R11: Synchronous reset clears both time-of-day counts and the configuration word, sets high to 1000 and low to 0, and leaves the pin at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick is NS_INC nanoseconds |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the register written |
| wr_data | input | DW | Write data |
| rd_addr | input | 5 | Byte offset of the register read |
| rd_data | output | DW | Read data, combinational from rd_addr |
| tod_sec | output | SEC_W | Time-of-day seconds |
| tod_ns | output | $clog2(NS_PER_SEC) | Time-of-day nanoseconds |
| pulse_out | output | 1 | Pulse output pin |

## Verification
The time-of-day counts and pulse_out are updated by the same clock edge, so the output level that belongs to nanoseconds value t appears in the same cycle as t. The bench samples both at the falling edge and compares them against a window computed from the programmed values, on every tick of a whole second. A write shows on rd_data one edge after the strobe, and reaches the waveform only at the next wrap. For that reason every table entry is written during one second, checked against the old settings for the rest of that second, and then checked against the new settings for the whole of the following second. Reset values appear one edge after rst is raised and are sampled at the following falling edge.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    // register map, byte offsets
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFF_CFG  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_HIGH = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_LOW  = 5'h18;

    // configuration word layout: [5:3] action, [2] sync, [1] polarity, [0] domain
    localparam int ACT_W = 3;
    localparam int CFG_W = ACT_W + 3;
    localparam logic [ACT_W-1:0] ACT_CLOCK = 3'd1;

    typedef struct packed {
        logic [ACT_W-1:0] action;
        logic             sync;
        logic             pol;
        logic             dom;
    } pin_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_HIGH  = 2'd2,
        ST_DONE  = 2'd3
    } pulse_state_e;

    function automatic logic cfg_enabled(input pin_cfg_t c);
        return (c.action == ACT_CLOCK) && c.sync;
    endfunction

endpackage

// File: rtl/tpg_tod.sv
module tpg_tod #(
    parameter int NS_PER_SEC = 1_000_000_000,
    parameter int NS_INC     = 4,
    parameter int SEC_W      = 32,
    localparam int NS_W      = $clog2(NS_PER_SEC)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [SEC_W-1:0] tod_sec,
    output logic [NS_W-1:0]  tod_ns,
    output logic [NS_W-1:0]  nxt_ns,
    output logic             roll
);

    localparam logic [NS_W:0] STEP  = (NS_W+1)'(NS_INC);
    localparam logic [NS_W:0] LIMIT = (NS_W+1)'(NS_PER_SEC);

    logic [NS_W:0] sum;

    always_comb begin
        sum  = {1'b0, tod_ns} + STEP;
        roll = (sum >= LIMIT);
        if (roll) begin
            nxt_ns = NS_W'(sum - LIMIT);
        end else begin
            nxt_ns = sum[NS_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tod_ns  <= '0;
            tod_sec <= '0;
        end else begin
            tod_ns <= nxt_ns;
            if (roll) begin
                tod_sec <= tod_sec + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tpg_regs.sv
module tpg_regs
    import tpg_pkg::*;
#(
    parameter int DW       = 32,
    parameter int HIGH_RST = 1000,
    parameter int LOW_RST  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              roll,
    output pin_cfg_t          live_cfg,
    output logic [DW-1:0]     live_high,
    output logic [DW-1:0]     live_low,
    output pin_cfg_t          act_cfg,
    output logic [DW-1:0]     act_high,
    output logic [DW-1:0]     act_low
);

    localparam logic [DW-1:0] HIGH_INIT = DW'(HIGH_RST);
    localparam logic [DW-1:0] LOW_INIT  = DW'(LOW_RST);

    // software-visible copies
    always_ff @(posedge clk) begin
        if (rst) begin
            live_cfg  <= '0;
            live_high <= HIGH_INIT;
            live_low  <= LOW_INIT;
        end else if (wr_en) begin
            unique case (wr_addr)
                OFF_CFG:  live_cfg  <= pin_cfg_t'(wr_data[CFG_W-1:0]);
                OFF_HIGH: live_high <= wr_data;
                OFF_LOW:  live_low  <= wr_data;
                default:  ;
            endcase
        end
    end

    // copies used by the sequencer, refreshed only at a rollover
    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg  <= '0;
            act_high <= HIGH_INIT;
            act_low  <= LOW_INIT;
        end else if (roll) begin
            act_cfg  <= live_cfg;
            act_high <= live_high;
            act_low  <= live_low;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            OFF_CFG:  rd_data[CFG_W-1:0] = live_cfg;
            OFF_HIGH: rd_data = live_high;
            OFF_LOW:  rd_data = live_low;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tpg_pulse_fsm.sv
module tpg_pulse_fsm
    import tpg_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NS_W = 30
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            roll,
    input  logic [NS_W-1:0] nxt_ns,
    input  pin_cfg_t        live_cfg,
    input  logic [DW-1:0]   live_high,
    input  logic [DW-1:0]   live_low,
    input  pin_cfg_t        act_cfg,
    input  logic [DW-1:0]   act_high,
    input  logic [DW-1:0]   act_low,
    output logic            pulse_out
);

    pulse_state_e state, state_nxt;
    logic [DW:0]  tick_ns;
    logic [DW:0]  act_stop;
    logic         unused_dom;

    assign unused_dom = live_cfg.dom ^ act_cfg.dom;

    // where a tick falls inside the window of the given settings
    function automatic pulse_state_e place(
        input logic [DW:0]   t,
        input pin_cfg_t      c,
        input logic [DW-1:0] hi,
        input logic [DW-1:0] lo
    );
        logic [DW:0] stop;
        stop = {1'b0, lo} + {1'b0, hi};
        if (!cfg_enabled(c) || (hi == '0)) begin
            return ST_IDLE;
        end else if (t < {1'b0, lo}) begin
            return ST_DELAY;
        end else if (t < stop) begin
            return ST_HIGH;
        end else begin
            return ST_DONE;
        end
    endfunction

    always_comb begin
        tick_ns  = (DW+1)'(nxt_ns);
        act_stop = {1'b0, act_low} + {1'b0, act_high};
    end

    // next state
    always_comb begin
        state_nxt = state;
        if (roll) begin
            // T_ROLL: new second, new settings
            state_nxt = place(tick_ns, live_cfg, live_high, live_low);
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_DELAY: begin
                    if (tick_ns >= act_stop) begin
                        state_nxt = ST_DONE;           // T_SKIP
                    end else if (tick_ns >= {1'b0, act_low}) begin
                        state_nxt = ST_HIGH;           // T_START
                    end
                end
                ST_HIGH: begin
                    if (tick_ns >= act_stop) begin
                        state_nxt = ST_DONE;           // T_END
                    end
                end
                ST_DONE:  state_nxt = ST_DONE;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // outputs
    always_comb begin
        pulse_out = act_cfg.pol;
        unique case (state)
            ST_HIGH:  pulse_out = ~act_cfg.pol;
            ST_IDLE,
            ST_DELAY,
            ST_DONE:  pulse_out = act_cfg.pol;
            default:  pulse_out = act_cfg.pol;
        endcase
    end

endmodule

// File: rtl/tod_pulse_gen.sv
module tod_pulse_gen
    import tpg_pkg::*;
#(
    parameter int NS_PER_SEC = 1_000_000_000,
    parameter int NS_INC     = 4,
    parameter int SEC_W      = 32,
    parameter int DW         = 32,
    parameter int HIGH_RST   = 1000,
    parameter int LOW_RST    = 0,
    localparam int NS_W      = $clog2(NS_PER_SEC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns,
    output logic              pulse_out
);

    logic            roll;
    logic [NS_W-1:0] nxt_ns;
    pin_cfg_t        live_cfg, act_cfg;
    logic [DW-1:0]   live_high, live_low, act_high, act_low;

    tpg_tod #(
        .NS_PER_SEC(NS_PER_SEC),
        .NS_INC    (NS_INC),
        .SEC_W     (SEC_W)
    ) u_tod (
        .clk    (clk),
        .rst    (rst),
        .tod_sec(tod_sec),
        .tod_ns (tod_ns),
        .nxt_ns (nxt_ns),
        .roll   (roll)
    );

    tpg_regs #(
        .DW      (DW),
        .HIGH_RST(HIGH_RST),
        .LOW_RST (LOW_RST)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .roll     (roll),
        .live_cfg (live_cfg),
        .live_high(live_high),
        .live_low (live_low),
        .act_cfg  (act_cfg),
        .act_high (act_high),
        .act_low  (act_low)
    );

    tpg_pulse_fsm #(
        .DW  (DW),
        .NS_W(NS_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .roll     (roll),
        .nxt_ns   (nxt_ns),
        .live_cfg (live_cfg),
        .live_high(live_high),
        .live_low (live_low),
        .act_cfg  (act_cfg),
        .act_high (act_high),
        .act_low  (act_low),
        .pulse_out(pulse_out)
    );

endmodule

// File: rtl/tpg_chk.sv
module tpg_chk
    import tpg_pkg::*;
#(
    parameter int NS_PER_SEC = 1_000_000_000,
    parameter int NS_INC     = 4,
    parameter int SEC_W      = 32,
    parameter int DW         = 32,
    localparam int NS_W      = $clog2(NS_PER_SEC)
) (
    input logic             clk,
    input logic             rst,
    input logic             roll,
    input logic [NS_W-1:0]  tod_ns,
    input logic [SEC_W-1:0] tod_sec,
    input logic             pulse_out,
    input pin_cfg_t         act_cfg,
    input logic [DW-1:0]    act_high,
    input logic [DW-1:0]    act_low
);

    logic [DW:0] t_ext, stop_ext;
    logic        en_now, unused_dom;

    assign unused_dom = act_cfg.dom;

    always_comb begin
        t_ext    = (DW+1)'(tod_ns);
        stop_ext = {1'b0, act_low} + {1'b0, act_high};
        en_now   = cfg_enabled(act_cfg) && (act_high != '0);
    end

    // R1: nanoseconds stay in range and step by the increment between wraps
    a_r1_ns_bound: assert property (@(posedge clk) disable iff (rst)
        tod_ns < NS_W'(NS_PER_SEC));
    a_r1_ns_step: assert property (@(posedge clk) disable iff (rst)
        !roll |=> (tod_ns == $past(tod_ns) + NS_W'(NS_INC)));

    // R2: seconds step once per wrap, hold otherwise
    a_r2_sec_carry: assert property (@(posedge clk) disable iff (rst)
        roll |=> (tod_sec == $past(tod_sec) + 1'b1));
    a_r2_sec_hold: assert property (@(posedge clk) disable iff (rst)
        !roll |=> $stable(tod_sec));

    // R3: active level inside the window of an enabled second
    a_r3_in_window: assert property (@(posedge clk) disable iff (rst)
        (en_now && (t_ext >= {1'b0, act_low}) && (t_ext < stop_ext))
            |-> (pulse_out == ~act_cfg.pol));

    // R4: inactive before the delay has elapsed
    a_r4_before_delay: assert property (@(posedge clk) disable iff (rst)
        (t_ext < {1'b0, act_low}) |-> (pulse_out == act_cfg.pol));

    // R5: inactive once the window has closed
    a_r5_after_end: assert property (@(posedge clk) disable iff (rst)
        (t_ext >= stop_ext) |-> (pulse_out == act_cfg.pol));

    // R7, R8: a disabled or zero-width second stays inactive
    a_r7_idle_level: assert property (@(posedge clk) disable iff (rst)
        !en_now |-> (pulse_out == act_cfg.pol));

endmodule

bind tod_pulse_gen tpg_chk #(
    .NS_PER_SEC(NS_PER_SEC),
    .NS_INC    (NS_INC),
    .SEC_W     (SEC_W),
    .DW        (DW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .roll     (roll),
    .tod_ns   (tod_ns),
    .tod_sec  (tod_sec),
    .pulse_out(pulse_out),
    .act_cfg  (act_cfg),
    .act_high (act_high),
    .act_low  (act_low)
);

// File: tb/tb_tod_pulse_gen.sv
`timescale 1ns/1ps
module tb_tod_pulse_gen;

    localparam int NSPS  = 2000;
    localparam int INC   = 4;
    localparam int TPS   = NSPS / INC;
    localparam int SEC_W = 32;
    localparam int DW    = 32;
    localparam int NS_W  = $clog2(NSPS);
    localparam int NV    = 9;

    // table: configuration word, high, low, requirement covered
    localparam logic [31:0] V_CFG [NV] = '{32'h0C, 32'h0C, 32'h0E, 32'h0D, 32'h0A,
                                           32'h0C, 32'h14, 32'h0E, 32'h0C};
    localparam logic [31:0] V_HI  [NV] = '{32'd1000, 32'd200, 32'd300, 32'd400, 32'd500,
                                           32'd0, 32'd500, 32'd2000, 32'd4};
    localparam logic [31:0] V_LO  [NV] = '{32'd0, 32'd400, 32'd100, 32'd1800, 32'd0,
                                           32'd100, 32'd0, 32'd0, 32'd1996};
    localparam string       V_TAG [NV] = '{"R3", "R4", "R6", "R5", "R7",
                                           "R8", "R7", "R5", "R3"};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [4:0]       wr_addr = '0;
    logic [DW-1:0]    wr_data = '0;
    logic [4:0]       rd_addr = '0;
    logic [DW-1:0]    rd_data;
    logic [SEC_W-1:0] tod_sec;
    logic [NS_W-1:0]  tod_ns;
    logic             pulse_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tod_pulse_gen #(
        .NS_PER_SEC(NSPS),
        .NS_INC    (INC),
        .SEC_W     (SEC_W),
        .DW        (DW)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .tod_sec  (tod_sec),
        .tod_ns   (tod_ns),
        .pulse_out(pulse_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_out(input logic [31:0] cfg, input logic [31:0] hi,
                                     input logic [31:0] lo, input logic [NS_W-1:0] ns);
        longint t, l, h;
        logic on;
        t  = longint'(ns);
        l  = longint'(lo);
        h  = longint'(hi);
        on = (cfg[5:3] == 3'd1) && cfg[2] && (hi != 0) && (t >= l) && (t < l + h);
        return on ^ cfg[1];
    endfunction

    task automatic read_reg(input logic [4:0] a, output logic [DW-1:0] v);
        rd_addr = a;
        #0.1;
        v = rd_data;
    endtask

    // one full second: compare every tick with the given settings, optionally writing new ones
    task automatic run_second(input logic [31:0] cfg, input logic [31:0] hi, input logic [31:0] lo,
                              input bit wr, input logic [31:0] ncfg, input logic [31:0] nhi,
                              input logic [31:0] nlo, input string req);
        int errs;
        int bad_ns;
        logic bad_got;
        errs = 0;
        bad_ns = -1;
        bad_got = 1'b0;
        while (tod_ns != '0) @(negedge clk);
        for (int i = 0; i < TPS; i++) begin
            if (pulse_out !== exp_out(cfg, hi, lo, tod_ns)) begin
                if (errs == 0) begin
                    bad_ns = int'(tod_ns);
                    bad_got = pulse_out;
                end
                errs++;
            end
            if (wr && i < 3) begin
                wr_en   = 1'b1;
                wr_addr = (i == 0) ? 5'h00 : ((i == 1) ? 5'h14 : 5'h18);
                wr_data = (i == 0) ? ncfg  : ((i == 1) ? nhi   : nlo);
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        check(errs == 0, req, $sformatf("ticks wrong (first at ns=%0d level=%0b)", bad_ns, bad_got),
              errs, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] v;
        logic [31:0] pc, ph, pl;

        // R11: reset state
        repeat (5) @(negedge clk);
        read_reg(5'h00, v); check(v == 0,    "R11", "cfg after reset", v, 0);
        read_reg(5'h14, v); check(v == 1000, "R11", "high after reset", v, 1000);
        read_reg(5'h18, v); check(v == 0,    "R11", "low after reset", v, 0);
        check(pulse_out == 1'b0, "R11", "pin after reset", pulse_out, 0);
        check(tod_ns == 0 && tod_sec == 0, "R11", "tod after reset", tod_ns, 0);
        rst = 1'b0;

        // R1, R2: 600 ticks of 4 ns from zero -> 1 s + 400 ns
        repeat (600) @(negedge clk);
        check(tod_ns == 11'd400, "R1", "ns after 600 ticks", tod_ns, 400);
        check(tod_sec == 1, "R2", "sec after 600 ticks", tod_sec, 1);
        check(pulse_out == 1'b0, "R7", "pin with cfg cleared", pulse_out, 0);

        // R10: unmapped write ignored, cfg upper bits dropped
        wr_en = 1'b1; wr_addr = 5'h04; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_addr = 5'h00; wr_data = 32'hFFFF_FFC0;
        @(negedge clk);
        wr_en = 1'b0;
        read_reg(5'h04, v); check(v == 0,    "R10", "unmapped read", v, 0);
        read_reg(5'h00, v); check(v == 0,    "R10", "cfg upper bits", v, 0);
        read_reg(5'h14, v); check(v == 1000, "R10", "high untouched", v, 1000);
        read_reg(5'h18, v); check(v == 0,    "R10", "low untouched", v, 0);

        // table walk: write during one second (old settings must hold, R9),
        // then check the full following second against the new settings
        pc = 32'h0; ph = 32'd1000; pl = 32'd0;
        for (int k = 0; k < NV; k++) begin
            run_second(pc, ph, pl, 1'b1, V_CFG[k], V_HI[k], V_LO[k], "R9");
            read_reg(5'h00, v);
            check(v == (V_CFG[k] & 32'h3F), "R10", "cfg readback", v, V_CFG[k] & 32'h3F);
            run_second(V_CFG[k], V_HI[k], V_LO[k], 1'b0, 0, 0, 0, V_TAG[k]);
            pc = V_CFG[k]; ph = V_HI[k]; pl = V_LO[k];
        end

        // R2: seconds count after all of the above
        check(tod_sec == SEC_W'(1 + 2 * NV + 1) || tod_sec == SEC_W'(1 + 2 * NV + 2),
              "R2", "sec after table", tod_sec, 1 + 2 * NV + 1);

        // R11: reset in the middle of a run restores defaults
        rst = 1'b1;
        @(negedge clk);
        read_reg(5'h00, v); check(v == 0,    "R11", "cfg after late reset", v, 0);
        read_reg(5'h14, v); check(v == 1000, "R11", "high after late reset", v, 1000);
        read_reg(5'h18, v); check(v == 0,    "R11", "low after late reset", v, 0);
        check(pulse_out == 1'b0, "R11", "pin after late reset", pulse_out, 0);
        check(tod_sec == 0 && tod_ns == 0, "R11", "tod after late reset", tod_sec, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule